// File: doc/BRIEF.md
# Serial Port with Status and Control Registers

This block puts one asynchronous serial channel on an 8-bit processor I/O bus. Two consecutive port addresses are decoded. The lower address is the control/status port: reads return a packed status byte and writes set two interrupt enables. The upper address is the data port: reads return the last received word and writes hand a word to the transmitter. The receiver and the transmitter each hold one word. The receiver checks every frame for parity and for a valid stop bit.

A frame has one low start bit, eight data bits sent least significant bit first, one parity bit and one high stop bit. A parameter picks even or odd parity. Bit timing comes from a fixed divisor `TICK_DIV`. That divisor gives a 16x oversampling tick, so one bit lasts 16*TICK_DIV clocks. The receiver confirms a start bit at its middle and then samples every later bit at its centre. Two interrupt request outputs tell the processor that a received word is waiting or that the transmitter can take another word.

Top module: `serial_port_ctl`

## Requirements
- R1: The control/status port is at address BASE_ADDR and the data port is at BASE_ADDR+1. A read at any other address returns 0x00, and writes to other addresses change nothing.
- R2: The status byte is laid out as follows. Bit 7 is 0 when the transmitter can take a word and 1 when it is busy. Bit 6 is always 0. Bit 5 is the word-available flag and bit 4 is the overrun flag. Bit 3 is the framing-error flag and bit 2 is the parity-error flag. Bit 1 is 1 when the transmitter is empty. Bit 0 is 0 when a received word is available and 1 otherwise.
- R3: A write to the control port loads the input interrupt enable from bit 0 and the output interrupt enable from bit 1. Bits 7..2 of the written byte have no effect.
- R4: After reset the status reads 0x03, the data port reads 0x00, `tx_line` is high, and both interrupt requests and both enables are 0.
- R5: A data-port write while the transmitter is empty sends one frame on `tx_line`: a 0 start bit, the data LSB first, the parity bit, and a 1 stop bit, each bit 16*TICK_DIV clocks long. Status bit 1 is 0 from the clock after the write until the stop bit has been sent.
- R6: A data-port write while the transmitter is busy is ignored. That word is never transmitted.
- R7: The receiver samples each bit at its middle. When the stop bit has been sampled, the word is placed in the data register and the word-available flag is set.
- R8: Reading the data port clears the word-available and overrun flags on that clock edge.
- R9: If a word completes while the word-available flag is still set, the new word replaces the stored one and the overrun flag is set.
- R10: The framing-error flag is set when the sampled stop bit is 0. The parity-error flag is set when the received parity bit does not match the selected parity. Both flags are rewritten for every received word.
- R11: With ODD_PARITY = 0 the parity bit makes the total number of ones in the data and parity bits even. With ODD_PARITY = 1 that total is odd. The setting applies to both transmit and receive.
- R12: `irq_in` is high exactly while the input enable and the word-available flag are both set. `irq_out` is high exactly while the output enable is set and the transmitter is empty.
- R13: A low pulse on `rx_line` shorter than half a bit time does not start a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 8 | I/O port address |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe; a data-port read has its side effect on the clock edge |
| bus_wr | input | 1 | Write strobe, acted on at the clock edge |
| bus_rdata | output | 8 | Read data from the addressed port (combinational) |
| rx_line | input | 1 | Serial receive line, idle high |
| tx_line | output | 1 | Serial transmit line, idle high |
| irq_in | output | 1 | Input interrupt request |
| irq_out | output | 1 | Output interrupt request |

## Verification
Received frames are taken from a table that pairs different data values with a good or bad parity bit and a good or bad stop bit. The parity and framing flags are read back separately and together, which shows that each flag follows only its own fault. Every frame is also received by a second instance set for the opposite parity, so the parity error it reports must be the inverse, which confirms the even/odd choice. Two frames sent back to back without a read show that the newer word is kept and the overrun flag is set. A short low pulse on the receive line shows that a glitch is rejected rather than taken as a start bit. Transmit frames are checked bit by bit from both instances, and a write while the transmitter is busy must never appear on the line.

// File: rtl/sio_pkg.sv
// Shared definitions for the serial port: receiver states, status bit
// positions (software decodes these) and the parity rule.
package sio_pkg;

    localparam int OVERSAMPLE  = 16;
    localparam int DATA_BITS   = 8;
    localparam int FRAME_BITS  = DATA_BITS + 3;

    // Status byte bit positions; their order is visible to software.
    localparam int ST_TX_BUSY  = 7;
    localparam int ST_UNUSED   = 6;
    localparam int ST_AVAIL    = 5;
    localparam int ST_OVERRUN  = 4;
    localparam int ST_FRAMING  = 3;
    localparam int ST_PARITY   = 2;
    localparam int ST_TX_EMPTY = 1;
    localparam int ST_RX_NRDY  = 0;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP,
        RX_HOLD
    } rx_state_t;

    // Parity bit that completes the frame for the chosen sense.
    function automatic logic frame_parity(input logic [DATA_BITS-1:0] d,
                                          input logic odd);
        return (^d) ^ odd;
    endfunction

endpackage

// File: rtl/sio_tick_gen.sv
// Oversampling tick generator.
// Emits a one-clock pulse every DIV clocks. Assumes DIV >= 2.
module sio_tick_gen #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CW-1:0] cnt;

    // Free-running divider; the tick is registered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == CW'(DIV - 1)) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/sio_tx.sv
// Serial transmitter with a single frame shift register.
// Assumes load is only honoured while idle. Shifts out start, data LSB
// first, parity and stop, each bit lasting OVERSAMPLE ticks.
module sio_tx
    import sio_pkg::*;
#(
    parameter bit ODD_PARITY = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 load,
    input  logic [DATA_BITS-1:0] din,
    output logic                 tx_line,
    output logic                 empty
);
    localparam int BW = $clog2(FRAME_BITS);
    localparam int OW = $clog2(OVERSAMPLE);

    logic [FRAME_BITS-1:0] sh;
    logic [BW-1:0]         bit_idx;
    logic [OW-1:0]         os_cnt;
    logic                  busy;
    logic                  par;

    // Parity sense is fixed at elaboration.
    generate
        if (ODD_PARITY) begin : g_odd
            assign par = frame_parity(din, 1'b1);
        end else begin : g_even
            assign par = frame_parity(din, 1'b0);
        end
    endgenerate

    // Frame load, bit timing and shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh      <= '1;
            bit_idx <= '0;
            os_cnt  <= '0;
            busy    <= 1'b0;
        end else if (!busy) begin
            if (load) begin
                sh      <= {1'b1, par, din, 1'b0};
                bit_idx <= '0;
                os_cnt  <= '0;
                busy    <= 1'b1;
            end
        end else if (tick) begin
            if (os_cnt == OW'(OVERSAMPLE - 1)) begin
                os_cnt <= '0;
                sh     <= {1'b1, sh[FRAME_BITS-1:1]};
                if (bit_idx == BW'(FRAME_BITS - 1)) begin
                    busy <= 1'b0;
                end else begin
                    bit_idx <= bit_idx + 1'b1;
                end
            end else begin
                os_cnt <= os_cnt + 1'b1;
            end
        end
    end

    assign tx_line = sh[0];
    assign empty   = !busy;
endmodule

// File: rtl/sio_rx.sv
// Serial receiver with 16x oversampling.
// Confirms the start bit at half a bit, then samples each bit at its centre.
// After a low stop bit it waits for the line to go high before re-arming.
// done pulses for one clock with data and error flags valid.
module sio_rx
    import sio_pkg::*;
#(
    parameter bit ODD_PARITY = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tick,
    input  logic                 rx_in,
    output logic                 done,
    output logic [DATA_BITS-1:0] data,
    output logic                 frame_err,
    output logic                 par_err
);
    localparam int OW = $clog2(OVERSAMPLE);
    localparam int DW = $clog2(DATA_BITS);

    rx_state_t            state;
    logic                 s1, s2;
    logic [OW-1:0]        os_cnt;
    logic [DW-1:0]        bit_idx;
    logic [DATA_BITS-1:0] sh;
    logic                 pbit;
    logic                 last_os;

    assign last_os = (os_cnt == OW'(OVERSAMPLE - 1));

    // Two-stage synchronizer on the asynchronous line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
        end else begin
            s1 <= rx_in;
            s2 <= s1;
        end
    end

    // Frame state machine with mid-bit sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= RX_IDLE;
            os_cnt    <= '0;
            bit_idx   <= '0;
            sh        <= '0;
            pbit      <= 1'b0;
            done      <= 1'b0;
            data      <= '0;
            frame_err <= 1'b0;
            par_err   <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                RX_IDLE: begin
                    if (!s2) begin
                        state  <= RX_START;
                        os_cnt <= '0;
                    end
                end
                RX_START: begin
                    if (tick) begin
                        if (os_cnt == OW'(OVERSAMPLE/2 - 1)) begin
                            os_cnt  <= '0;
                            bit_idx <= '0;
                            state   <= s2 ? RX_IDLE : RX_DATA;
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                end
                RX_DATA: begin
                    if (tick) begin
                        if (last_os) begin
                            os_cnt <= '0;
                            sh     <= {s2, sh[DATA_BITS-1:1]};
                            if (bit_idx == DW'(DATA_BITS - 1)) begin
                                state <= RX_PAR;
                            end else begin
                                bit_idx <= bit_idx + 1'b1;
                            end
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                end
                RX_PAR: begin
                    if (tick) begin
                        if (last_os) begin
                            os_cnt <= '0;
                            pbit   <= s2;
                            state  <= RX_STOP;
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                end
                RX_STOP: begin
                    if (tick) begin
                        if (last_os) begin
                            os_cnt    <= '0;
                            done      <= 1'b1;
                            data      <= sh;
                            frame_err <= !s2;
                            par_err   <= (pbit != frame_parity(sh, ODD_PARITY));
                            state     <= s2 ? RX_IDLE : RX_HOLD;
                        end else begin
                            os_cnt <= os_cnt + 1'b1;
                        end
                    end
                end
                RX_HOLD: begin
                    if (s2) begin
                        state <= RX_IDLE;
                    end
                end
                default: state <= RX_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/serial_port_ctl.sv
// Two-address serial port on an 8-bit I/O bus.
// BASE_ADDR is control/status and BASE_ADDR+1 is data. Read data is a
// combinational mux. A data read clears the receive flags on the edge.
// Assumes strobes are synchronous to clk and last one cycle per access.
module serial_port_ctl
    import sio_pkg::*;
#(
    parameter logic [7:0] BASE_ADDR  = 8'h00,
    parameter int         TICK_DIV   = 4,
    parameter bit         ODD_PARITY = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] bus_addr,
    input  logic [7:0] bus_wdata,
    input  logic       bus_rd,
    input  logic       bus_wr,
    output logic [7:0] bus_rdata,
    input  logic       rx_line,
    output logic       tx_line,
    output logic       irq_in,
    output logic       irq_out
);
    localparam logic [7:0] CTL_ADDR  = BASE_ADDR;
    localparam logic [7:0] DATA_ADDR = BASE_ADDR + 8'd1;

    logic                 tick;
    logic                 sel_ctl, sel_dat;
    logic                 tx_load, tx_empty, data_rd;
    logic                 rx_done, rx_fe, rx_pe;
    logic [DATA_BITS-1:0] rx_data;
    logic [DATA_BITS-1:0] rx_buf;
    logic                 avail, ovr, fe_q, pe_q;
    logic                 ie_in, ie_out;
    logic [7:0]           status;

    assign sel_ctl = (bus_addr == CTL_ADDR);
    assign sel_dat = (bus_addr == DATA_ADDR);
    assign tx_load = bus_wr && sel_dat && tx_empty;
    assign data_rd = bus_rd && sel_dat;

    sio_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick)
    );

    sio_tx #(.ODD_PARITY(ODD_PARITY)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .load    (tx_load),
        .din     (bus_wdata),
        .tx_line (tx_line),
        .empty   (tx_empty)
    );

    sio_rx #(.ODD_PARITY(ODD_PARITY)) u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .rx_in     (rx_line),
        .done      (rx_done),
        .data      (rx_data),
        .frame_err (rx_fe),
        .par_err   (rx_pe)
    );

    // Receive buffer and its flags; a completed word takes priority over a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_buf <= '0;
            avail  <= 1'b0;
            ovr    <= 1'b0;
            fe_q   <= 1'b0;
            pe_q   <= 1'b0;
        end else if (rx_done) begin
            rx_buf <= rx_data;
            avail  <= 1'b1;
            ovr    <= (avail || ovr) && !data_rd;
            fe_q   <= rx_fe;
            pe_q   <= rx_pe;
        end else if (data_rd) begin
            avail <= 1'b0;
            ovr   <= 1'b0;
        end
    end

    // Interrupt enables from control writes; upper bits are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ie_in  <= 1'b0;
            ie_out <= 1'b0;
        end else if (bus_wr && sel_ctl) begin
            ie_in  <= bus_wdata[0];
            ie_out <= bus_wdata[1];
        end
    end

    // Pack the status byte.
    always_comb begin
        status              = '0;
        status[ST_TX_BUSY]  = !tx_empty;
        status[ST_UNUSED]   = 1'b0;
        status[ST_AVAIL]    = avail;
        status[ST_OVERRUN]  = ovr;
        status[ST_FRAMING]  = fe_q;
        status[ST_PARITY]   = pe_q;
        status[ST_TX_EMPTY] = tx_empty;
        status[ST_RX_NRDY]  = !avail;
    end

    // Read data mux for the addressed port.
    always_comb begin
        if (sel_ctl)      bus_rdata = status;
        else if (sel_dat) bus_rdata = rx_buf;
        else              bus_rdata = 8'h00;
    end

    assign irq_in  = ie_in && avail;
    assign irq_out = ie_out && tx_empty;
endmodule

// File: rtl/sio_checker.sv
// Assertion checker for serial_port_ctl, attached by bind.
// Observes bus strobes, outputs and the internal flag registers.
module sio_checker #(
    parameter logic [7:0] BASE_ADDR = 8'h00
) (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] bus_addr,
    input logic [7:0] bus_wdata,
    input logic       bus_rd,
    input logic       bus_wr,
    input logic       tx_line,
    input logic       irq_in,
    input logic       irq_out,
    input logic       avail,
    input logic       ovr,
    input logic       tx_empty,
    input logic       ie_in,
    input logic       ie_out,
    input logic       rx_done
);
    localparam logic [7:0] CTL_A = BASE_ADDR;
    localparam logic [7:0] DAT_A = BASE_ADDR + 8'd1;

    // R3: control write loads the enables from bits 0 and 1
    p_ctl_enables_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == CTL_A) |=>
            (ie_in == $past(bus_wdata[0]) && ie_out == $past(bus_wdata[1])));

    // R5: an idle transmitter holds the line high
    p_idle_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> tx_line);

    // R5: accepted data write makes the transmitter busy
    p_load_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == DAT_A && tx_empty) |=> !tx_empty);

    // R7: a finished frame sets word available
    p_done_avail_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done |=> avail);

    // R8: data read with no new word clears both flags
    p_read_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == DAT_A && !rx_done) |=> (!avail && !ovr));

    // R9: overrun only rises when a word was already waiting
    p_overrun_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr) |-> ($past(avail) && $past(rx_done)));

    // R12: request outputs need their enable and condition
    p_irq_in_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_in |-> (ie_in && avail));

    p_irq_out_r12: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (ie_out && tx_empty));
endmodule

bind serial_port_ctl sio_checker #(.BASE_ADDR(BASE_ADDR)) u_sio_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .tx_line   (tx_line),
    .irq_in    (irq_in),
    .irq_out   (irq_out),
    .avail     (avail),
    .ovr       (ovr),
    .tx_empty  (tx_empty),
    .ie_in     (ie_in),
    .ie_out    (ie_out),
    .rx_done   (rx_done)
);

// File: tb/serial_port_ctl_test.sv
// Bench for serial_port_ctl: table of received frames, then directed tests.
// A second instance with odd parity shares the bus and the receive line.
module serial_port_ctl_test;
    localparam logic [7:0] BASE = 8'h00;
    localparam int         DIV  = 4;
    localparam int         BITC = 16 * DIV;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic [7:0] bus_wdata = 8'h00;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic       rx_line = 1'b1;
    logic [7:0] rdata_e, rdata_o;
    logic       tx_e, tx_o, irqi_e, irqo_e, irqi_o, irqo_o;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #10 clk = ~clk;

    serial_port_ctl #(.BASE_ADDR(BASE), .TICK_DIV(DIV), .ODD_PARITY(1'b0)) uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(rdata_e), .rx_line(rx_line),
        .tx_line(tx_e), .irq_in(irqi_e), .irq_out(irqo_e));

    serial_port_ctl #(.BASE_ADDR(BASE), .TICK_DIV(DIV), .ODD_PARITY(1'b1)) uut_odd (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(rdata_o), .rx_line(rx_line),
        .tx_line(tx_o), .irq_in(irqi_o), .irq_out(irqo_o));

    // Rows: {data, bad parity, bad stop, expected status after receipt}
    localparam int NROW = 6;
    localparam logic [17:0] ROWS [NROW] = '{
        {8'hA5, 1'b0, 1'b0, 8'h22},
        {8'h00, 1'b0, 1'b0, 8'h22},
        {8'hFF, 1'b1, 1'b0, 8'h26},
        {8'h3C, 1'b0, 1'b1, 8'h2A},
        {8'h81, 1'b1, 1'b1, 8'h2E},
        {8'h7E, 1'b0, 1'b0, 8'h22}
    };

    task automatic chk(input string tag, input logic [10:0] act, input logic [10:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] ve, output logic [7:0] vo);
        @(negedge clk);
        bus_addr = a;
        bus_rd   = 1'b1;
        #2;
        ve = rdata_e;
        vo = rdata_o;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic send_frame(input logic [7:0] d, input logic bad_par, input logic bad_stop);
        logic [10:0] f;
        f = {~bad_stop, (^d) ^ bad_par, d, 1'b0};
        for (int i = 0; i < 11; i++) begin
            @(negedge clk);
            rx_line = f[i];
            repeat (BITC - 1) @(negedge clk);
        end
        @(negedge clk);
        rx_line = 1'b1;
        repeat (10) @(negedge clk);
    endtask

    // Capture one frame from both transmit lines at mid-bit.
    task automatic grab_tx(output logic [10:0] fe, output logic [10:0] fo);
        int n;
        n = 0;
        while (tx_e !== 1'b0 && n < 400) begin
            @(negedge clk);
            n++;
        end
        repeat (BITC / 2) @(negedge clk);
        for (int i = 0; i < 11; i++) begin
            fe[i] = tx_e;
            fo[i] = tx_o;
            if (i < 10) repeat (BITC) @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] ve, vo;
        logic [10:0] fe, fo;

        repeat (10) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);

        // R4: reset state
        bus_read(BASE, ve, vo);
        chk("R4 status", {3'b0, ve}, 11'h003);
        bus_read(BASE + 8'd1, ve, vo);
        chk("R4 data", {3'b0, ve}, 11'h000);
        chk("R4 lines", {7'b0, tx_e, irqi_e, irqo_e, 1'b0}, 11'h008);

        // R1: unmapped address reads zero
        bus_read(BASE + 8'd2, ve, vo);
        chk("R1 unmapped", {3'b0, ve}, 11'h000);

        // R7 R10 R11 R2: table of received frames
        for (int r = 0; r < NROW; r++) begin
            send_frame(ROWS[r][17:10], ROWS[r][9], ROWS[r][8]);
            bus_read(BASE, ve, vo);
            chk("R2 R10 status", {3'b0, ve}, {3'b0, ROWS[r][7:0]});
            chk("R11 odd status", {3'b0, vo}, {3'b0, ROWS[r][7:0] ^ 8'h04});
            bus_read(BASE + 8'd1, ve, vo);
            chk("R7 data", {3'b0, ve}, {3'b0, ROWS[r][17:10]});
            bus_read(BASE, ve, vo);
            chk("R8 status after read", {3'b0, ve}, {3'b0, (ROWS[r][7:0] & 8'h0C) | 8'h03});
        end

        // R9: overrun keeps the newer word
        send_frame(8'h11, 1'b0, 1'b0);
        send_frame(8'h22, 1'b0, 1'b0);
        bus_read(BASE, ve, vo);
        chk("R9 overrun status", {3'b0, ve}, 11'h032);
        bus_read(BASE + 8'd1, ve, vo);
        chk("R9 newer word", {3'b0, ve}, 11'h022);
        bus_read(BASE, ve, vo);
        chk("R8 flags cleared", {3'b0, ve}, 11'h003);

        // R13: short low glitch is not a start bit
        @(negedge clk);
        rx_line = 1'b0;
        repeat (BITC / 2 - 12) @(negedge clk);
        rx_line = 1'b1;
        repeat (12 * BITC) @(negedge clk);
        bus_read(BASE, ve, vo);
        chk("R13 glitch ignored", {3'b0, ve}, 11'h003);

        // R3 R12: enables and requests
        bus_write(BASE, 8'hFC);
        #2;
        chk("R3 upper bits ignored", {9'b0, irqi_e, irqo_e}, 11'h000);
        bus_write(BASE, 8'h02);
        #2;
        chk("R12 irq_out on empty", {9'b0, irqi_e, irqo_e}, 11'h001);
        bus_write(BASE, 8'h01);
        #2;
        chk("R3 irq_in only", {9'b0, irqi_e, irqo_e}, 11'h000);
        send_frame(8'h4D, 1'b0, 1'b0);
        chk("R12 irq_in on avail", {9'b0, irqi_e, irqo_e}, 11'h002);
        bus_read(BASE + 8'd1, ve, vo);
        #2;
        chk("R12 irq_in after read", {9'b0, irqi_e, irqo_e}, 11'h000);

        // R5 R6 R11: transmit
        bus_write(BASE, 8'h02);
        bus_write(BASE + 8'd1, 8'h5A);
        #2;
        chk("R12 irq_out busy", {10'b0, irqo_e}, 11'h000);
        bus_read(BASE, ve, vo);
        chk("R5 busy status", {3'b0, ve}, 11'h081);
        bus_write(BASE + 8'd1, 8'hC3);
        grab_tx(fe, fo);
        chk("R5 R6 even frame", fe, {1'b1, ^8'h5A, 8'h5A, 1'b0});
        chk("R11 odd frame", fo, {1'b1, ~^8'h5A, 8'h5A, 1'b0});
        repeat (BITC + 16) @(negedge clk);
        bus_read(BASE, ve, vo);
        chk("R5 empty after stop", {3'b0, ve}, 11'h003);
        chk("R12 irq_out back", {10'b0, irqo_e}, 11'h001);
        begin
            int lows;
            lows = 0;
            for (int i = 0; i < 4 * BITC; i++) begin
                @(negedge clk);
                if (tx_e !== 1'b1) lows++;
            end
            chk("R6 no second frame", lows[10:0], 11'h000);
        end

        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule